// File: doc/BRIEF.md
# Register-Write Instruction Packer

This block turns a stream of register write requests into a compact buffer of instruction words for a later executor to fetch. Each request carries a 20-bit register offset, a 32-bit value and a flag that says whether it is a plain write or an auto-incrementing write to an indexed register. The packer stores the instructions in a local buffer of 32-bit words. A consumer read port lets the executor, or any other reader, fetch them.

A plain write takes two words: the value, then a header. An indexed write opens an instruction on an even word index. That instruction holds a count word, a header and the value. If the next request is an indexed write to the same register, the packer does not open a new instruction. It appends the value and raises the stored count. After every indexed write, a zero pad word keeps the instruction an even number of words long.

The packer reports the used length in bytes. It drops any request that would not fit and raises a sticky overflow flag. A flush pulse after a commit empties the buffer.

Top module: `regwr_packer`

## Requirements
- R1: A plain write puts the value at the current free index F and a header at F+1. The header is opcode 0x01 in bits 31:24, byte enables 0xF in bits 23:20 and the offset in bits 19:0. The free index becomes F+2, and F is not rounded to even first.
- R2: An indexed write that does not merge opens a new instruction at S, which is F rounded up to the next even index. It writes count 1 at S, a header with opcode 0x09, byte-enable field 0 and the offset at S+1, and the value at S+2. The free index becomes S+3.
- R3: An indexed write merges when the current instruction is indexed and has the same offset. It puts the value at F, writes the incremented count into the count word of that instruction, and advances the free index by one. A plain write or a different offset ends merging.
- R4: After an indexed write leaves the free index odd, the word at that index is written as zero, and it is not counted in the length.
- R5: `used_bytes` always equals four times the free index.
- R6: A request is dropped when its words, including any pad word, would not all fit below DEPTH. A dropped request changes neither the buffer nor the length, and it sets `overflow`, which stays high until flush or reset.
- R7: A flush pulse clears the length, `overflow` and the merge state, so the next indexed write opens a new instruction at index 0.
- R8: After a request is accepted, `req_ready` stays low for one cycle fewer than the number of words written: 1 for plain, 3 for a new indexed instruction, 2 for a merge that needs a pad and 1 for a merge that does not. A dropped request never lowers it.
- R9: After reset, `used_bytes` is 0, `overflow` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empties the buffer and clears the merge state and overflow |
| req_valid | input | 1 | A write request is offered |
| req_ready | output | 1 | The packer can take a request this cycle |
| req_indexed | input | 1 | 1 = indexed (auto-increment) write, 0 = plain write |
| req_offset | input | 20 | Register offset |
| req_data | input | 32 | Register value |
| overflow | output | 1 | Sticky: a request was dropped for lack of space |
| used_bytes | output | AW+3 | Used length in bytes |
| rd_addr | input | AW | Consumer read word index |
| rd_data | output | 32 | Buffer word (one cycle later when READ_REG=1) |

## Verification
The assertions take for granted that the inputs are known at every sampling edge. They also assume flush is only a pulse, so a hold-off longer than three cycles can only come from the packer's own word sequence. The progress check relies on a request never being accepted in a flush cycle. `req_ready` already guarantees this, because it is low during flush. The stimulus drives every input on falling edges from defined values, keeps valid low during reset and holds flush for exactly one cycle, so it stays inside these assumptions.

// File: rtl/regwr_packer_pkg.sv
package regwr_packer_pkg;
   localparam int WORD_W = 32;
   localparam int OFF_W  = 20;

   typedef enum logic [1:0] {
      PK_PLAIN   = 2'd0,
      PK_IDX_NEW = 2'd1,
      PK_IDX_ADD = 2'd2
   } pk_kind_e;

   localparam logic [7:0] OPC_PLAIN = 8'h01;
   localparam logic [7:0] OPC_INDEX = 8'h09;
   localparam logic [3:0] BE_ALL    = 4'hF;
   localparam logic [3:0] BE_NONE   = 4'h0;

   function automatic logic [WORD_W-1:0] pk_header(input logic [7:0] opc,
                                                   input logic [3:0] be,
                                                   input logic [OFF_W-1:0] off);
      return {opc, be, off};
   endfunction
endpackage

// File: rtl/regwr_packer_ram.sv
module regwr_packer_ram #(
   parameter int DEPTH    = 64,
   parameter int AW       = 6,
   parameter bit READ_REG = 1'b1
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [31:0]   wdata,
   input  logic [AW-1:0] raddr,
   output logic [31:0]   rdata
);
   logic [31:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   generate
      if (READ_REG) begin : g_rd_reg
         always_ff @(posedge clk) rdata <= mem[raddr];
      end else begin : g_rd_comb
         assign rdata = mem[raddr];
      end
   endgenerate
endmodule

// File: rtl/regwr_packer_step.sv
module regwr_packer_step
   import regwr_packer_pkg::*;
#(
   parameter int AW = 6
) (
   input  pk_kind_e         kind,
   input  logic [1:0]       step,
   input  logic [AW-1:0]    base,
   input  logic [AW-1:0]    start,
   input  logic [OFF_W-1:0] off,
   input  logic [31:0]      data,
   input  logic [31:0]      cnt,
   output logic [AW-1:0]    waddr,
   output logic [31:0]      wdata
);
   always_comb begin
      waddr = base + AW'(step);
      wdata = '0;
      case (kind)
         PK_PLAIN: begin
            wdata = (step == 2'd0) ? data : pk_header(OPC_PLAIN, BE_ALL, off);
         end
         PK_IDX_NEW: begin
            case (step)
               2'd0:    wdata = 32'd1;
               2'd1:    wdata = pk_header(OPC_INDEX, BE_NONE, off);
               2'd2:    wdata = data;
               default: wdata = '0;
            endcase
         end
         PK_IDX_ADD: begin
            case (step)
               2'd0:    wdata = data;
               2'd1: begin
                  waddr = start;
                  wdata = cnt;
               end
               default: begin
                  waddr = base + AW'(1);
                  wdata = '0;
               end
            endcase
         end
         default: wdata = '0;
      endcase
   end
endmodule

// File: rtl/regwr_packer.sv
module regwr_packer
   import regwr_packer_pkg::*;
#(
   parameter int DEPTH    = 64,
   parameter bit READ_REG = 1'b1,
   localparam int AW      = $clog2(DEPTH),
   localparam int PW      = AW + 1,
   localparam int LW      = AW + 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_indexed,
   input  logic [OFF_W-1:0] req_offset,
   input  logic [31:0]      req_data,
   output logic             overflow,
   output logic [LW-1:0]    used_bytes,
   input  logic [AW-1:0]    rd_addr,
   output logic [31:0]      rd_data
);
   generate
      if (DEPTH < 4 || (DEPTH % 2) != 0 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("regwr_packer: DEPTH must be a power of two of at least 4");
      end
   endgenerate

   logic             busy_q;
   logic [1:0]       step_q, last_q;
   pk_kind_e         kind_q;
   logic [OFF_W-1:0] off_q;
   logic [31:0]      data_q;
   logic [AW-1:0]    base_q;
   logic [PW-1:0]    fp_q;
   logic [AW-1:0]    start_q;
   logic [31:0]      cnt_q;
   logic             cur_idx_q;
   logic [OFF_W-1:0] cur_off_q;
   logic             ovf_q;

   logic             accept, fits, take, merge;
   pk_kind_e         kind_in;
   logic [PW-1:0]    aligned;
   logic [AW-1:0]    base_in;
   logic [PW:0]      end_in;
   logic [2:0]       words;

   assign req_ready  = ~busy_q & ~flush;
   assign accept     = req_valid & req_ready;
   assign merge      = req_indexed & cur_idx_q & (cur_off_q == req_offset);
   assign aligned    = fp_q + PW'(fp_q[0]);
   assign overflow   = ovf_q;
   assign used_bytes = {fp_q, 2'b00};

   always_comb begin
      kind_in = PK_PLAIN;
      base_in = fp_q[AW-1:0];
      end_in  = {1'b0, fp_q} + (PW+1)'(2);
      words   = 3'd2;
      if (req_indexed && !merge) begin
         kind_in = PK_IDX_NEW;
         base_in = aligned[AW-1:0];
         end_in  = {1'b0, aligned} + (PW+1)'(4);
         words   = 3'd4;
      end else if (merge) begin
         kind_in = PK_IDX_ADD;
         end_in  = {1'b0, fp_q} + (PW+1)'(2) - (PW+1)'(fp_q[0]);
         words   = fp_q[0] ? 3'd2 : 3'd3;
      end
   end

   assign fits = (end_in <= (PW+1)'(DEPTH));
   assign take = accept & fits;

   pk_kind_e         kind_s;
   logic [1:0]       step_s;
   logic [AW-1:0]    base_s;
   logic [OFF_W-1:0] off_s;
   logic [31:0]      data_s;
   logic [AW-1:0]    waddr;
   logic [31:0]      wdata;

   assign kind_s = busy_q ? kind_q : kind_in;
   assign step_s = busy_q ? step_q : 2'd0;
   assign base_s = busy_q ? base_q : base_in;
   assign off_s  = busy_q ? off_q  : req_offset;
   assign data_s = busy_q ? data_q : req_data;

   regwr_packer_step #(.AW(AW)) u_step (
      .kind  (kind_s),
      .step  (step_s),
      .base  (base_s),
      .start (start_q),
      .off   (off_s),
      .data  (data_s),
      .cnt   (cnt_q),
      .waddr (waddr),
      .wdata (wdata)
   );

   regwr_packer_ram #(.DEPTH(DEPTH), .AW(AW), .READ_REG(READ_REG)) u_ram (
      .clk   (clk),
      .we    (busy_q | take),
      .waddr (waddr),
      .wdata (wdata),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         step_q    <= '0;
         last_q    <= '0;
         kind_q    <= PK_PLAIN;
         off_q     <= '0;
         data_q    <= '0;
         base_q    <= '0;
         fp_q      <= '0;
         start_q   <= '0;
         cnt_q     <= '0;
         cur_idx_q <= 1'b0;
         cur_off_q <= '0;
         ovf_q     <= 1'b0;
      end else if (flush) begin
         busy_q    <= 1'b0;
         step_q    <= '0;
         fp_q      <= '0;
         start_q   <= '0;
         cnt_q     <= '0;
         cur_idx_q <= 1'b0;
         ovf_q     <= 1'b0;
      end else begin
         if (busy_q) begin
            step_q <= step_q + 2'd1;
            if (step_q == last_q) busy_q <= 1'b0;
         end
         if (accept && !fits) ovf_q <= 1'b1;
         if (take) begin
            kind_q <= kind_in;
            off_q  <= req_offset;
            data_q <= req_data;
            base_q <= base_in;
            busy_q <= 1'b1;
            step_q <= 2'd1;
            last_q <= 2'(words - 3'd1);
            case (kind_in)
               PK_IDX_NEW: begin
                  fp_q      <= aligned + PW'(3);
                  start_q   <= aligned[AW-1:0];
                  cnt_q     <= 32'd1;
                  cur_idx_q <= 1'b1;
                  cur_off_q <= req_offset;
               end
               PK_IDX_ADD: begin
                  fp_q  <= fp_q + PW'(1);
                  cnt_q <= cnt_q + 32'd1;
               end
               default: begin
                  fp_q      <= fp_q + PW'(2);
                  start_q   <= fp_q[AW-1:0];
                  cur_idx_q <= 1'b0;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/regwr_packer_chk.sv
module regwr_packer_chk #(
   parameter int DEPTH = 64,
   parameter int LW    = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          flush,
   input logic          req_valid,
   input logic          req_ready,
   input logic          overflow,
   input logic [LW-1:0] used_bytes
);
   logic [2:0] busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_run <= '0;
      else if (req_ready || flush) busy_run <= '0;
      else if (busy_run != 3'd7) busy_run <= busy_run + 3'd1;
   end

   assert_len_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      int'(used_bytes) <= DEPTH * 4);

   assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !flush) |=> overflow);

   assert_flush_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (used_bytes == '0 && !overflow));

   assert_accept_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (used_bytes != $past(used_bytes)) || overflow);

   assert_accept_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> int'(used_bytes) <= int'($past(used_bytes)) + 16);

   assert_holdoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= 3'd3);
endmodule

bind regwr_packer regwr_packer_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flush      (flush),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .overflow   (overflow),
   .used_bytes (used_bytes)
);

// File: tb/tb_regwr_packer.sv
module tb_regwr_packer;
   localparam int D  = 16;
   localparam int AW = 4;
   localparam int LW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_indexed = 1'b0;
   logic [19:0]   req_offset = '0;
   logic [31:0]   req_data = '0;
   logic          overflow;
   logic [LW-1:0] used_bytes;
   logic [AW-1:0] rd_addr = '0;
   logic [31:0]   rd_data;

   always #5 clk = ~clk;

   regwr_packer #(.DEPTH(D), .READ_REG(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
      .req_ready(req_ready), .req_indexed(req_indexed), .req_offset(req_offset),
      .req_data(req_data), .overflow(overflow), .used_bytes(used_bytes),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [31:0] m [D];
   bit          mv [D];
   int          fp = 0, st = 0, cnt = 0;
   bit          cur = 1'b0, ovf = 1'b0;
   logic [19:0] coff = '0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put(input int a, input logic [31:0] v);
      m[a]  = v;
      mv[a] = 1'b1;
   endtask

   task automatic model(input bit idx, input logic [19:0] off, input logic [31:0] data,
                        output int eb);
      int s;
      eb = 0;
      if (!idx) begin
         if (fp + 2 > D) ovf = 1'b1;
         else begin
            put(fp, data);
            put(fp + 1, {8'h01, 4'hF, off});
            st = fp; fp = fp + 2; cur = 1'b0; eb = 1;
         end
      end else if (cur && off == coff) begin
         if (fp + 2 - (fp % 2) > D) ovf = 1'b1;
         else begin
            put(fp, data);
            cnt = cnt + 1;
            put(st, cnt);
            fp = fp + 1; eb = 1;
            if (fp % 2 == 1) begin
               put(fp, 32'd0); eb = 2;
            end
         end
      end else begin
         s = fp + (fp % 2);
         if (s + 4 > D) ovf = 1'b1;
         else begin
            put(s, 32'd1);
            put(s + 1, {8'h09, 4'h0, off});
            put(s + 2, data);
            put(s + 3, 32'd0);
            st = s; fp = s + 3; cnt = 1; cur = 1'b1; coff = off; eb = 3;
         end
      end
   endtask

   task automatic send(input bit idx, input logic [19:0] off, input logic [31:0] data);
      int eb;
      int busy;
      model(idx, off, data, eb);
      @(negedge clk);
      req_valid = 1'b1; req_indexed = idx; req_offset = off; req_data = data;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      busy = 0;
      while (!req_ready && busy < 10) begin
         busy++;
         @(negedge clk);
      end
      chk("R8 ready hold-off", busy, eb);
      chk("R5 used length", 32'(used_bytes), fp * 4);
      chk("R6 overflow flag", 32'(overflow), 32'(ovf));
   endtask

   task automatic rd(input int a, output logic [31:0] v);
      @(negedge clk);
      rd_addr = a[AW-1:0];
      @(negedge clk);
      v = rd_data;
   endtask

   task automatic dump();
      logic [31:0] v;
      for (int a = 0; a < D; a++) begin
         if (mv[a]) begin
            rd(a, v);
            chk("buffer word R1 R2 R3 R4", v, m[a]);
         end
      end
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      fp = 0; st = 0; cnt = 0; cur = 1'b0; ovf = 1'b0;
      chk("R7 length after flush", 32'(used_bytes), 32'd0);
      chk("R7 overflow after flush", 32'(overflow), 32'd0);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 reset length", 32'(used_bytes), 32'd0);
      chk("R9 reset overflow", 32'(overflow), 32'd0);
      chk("R9 reset ready", 32'(req_ready), 32'd1);

      send(1'b0, 20'h00A10, 32'hA0A0_0001);
      send(1'b1, 20'h00B20, 32'hB000_0001);
      send(1'b1, 20'h00B20, 32'hB000_0002);
      send(1'b1, 20'h00B20, 32'hB000_0003);
      send(1'b1, 20'h00C30, 32'hC000_0001);
      send(1'b0, 20'h00C30, 32'hD000_0001);
      rd(1, v);  chk("R1 plain header", v, 32'h01F0_0A10);
      rd(3, v);  chk("R2 indexed header", v, 32'h0900_0B20);
      rd(2, v);  chk("R3 merged count", v, 32'd3);
      rd(7, v);  chk("R4 pad word", v, 32'd0);
      rd(8, v);  chk("R2 even start count", v, 32'd1);
      rd(11, v); chk("R1 unaligned plain value", v, 32'hD000_0001);
      chk("R4 pad not counted", 32'(used_bytes), 32'd52);
      send(1'b1, 20'h00C30, 32'hE000_0001);
      chk("R6 drop sets overflow", 32'(overflow), 32'd1);
      send(1'b0, 20'h00E40, 32'hF000_0001);
      chk("R6 overflow sticky", 32'(overflow), 32'd1);
      dump();

      do_flush();
      send(1'b1, 20'h00B20, 32'h1234_5678);
      rd(0, v); chk("R7 new instruction after flush", v, 32'd1);
      chk("R7 length after restart", 32'(used_bytes), 32'd12);

      for (int p = 0; p < 40; p++) begin
         do_flush();
         for (int i = 0; i < 12; i++) begin
            send(((p * 7 + i * 3) % 5) != 0, 20'((p + i / 3) % 3) + 20'h100,
                 32'(p * 256 + i));
         end
         dump();
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule